// File: doc/BRIEF.md
# Potentiometer Scan-Line Converter

This block runs an integrating conversion for the two resistive inputs (X and Y) of one controller port, using scan-line timing as its time base. At each field start it drives a discharge control that empties the external timing capacitors and holds its line counter at zero. The interval lasts seven scan lines in the 525-line timing mode and eight in the 625-line mode. After that interval the capacitors charge through the external resistance and the counter advances once per scan line.

Each channel has a comparator. The comparator reaches the block as a digital input that goes high once the capacitor voltage crosses the threshold. When a channel's comparator first goes high, that channel freezes at the current line count. A larger resistance charges more slowly, so it gives a larger count. Until a channel crosses, its field in the result follows the running count, so the result can be read at any moment. The Y value occupies the upper byte of the result and the X value the lower byte.

Top module: `pot_line_counter`

## Requirements
- R1: After reset, `discharge` is 0 and `result` is 0.
- R2: `field_start` sets `discharge` to 1. It stays 1 for exactly 7 `line_tick` pulses when `long_discharge` was 0 at the field start, or 8 pulses when it was 1. It drops on the clock edge that takes the last of those pulses.
- R3: While `discharge` is 1, `result` is 0 and both comparator inputs are ignored.
- R4: Once `discharge` is 0, each `line_tick` raises the line count by exactly one.
- R5: A channel that has not latched shows the running line count. Y appears in `result[15:8]` and X in `result[7:0]`.
- R6: If a channel's comparator is 1 at a clock edge while `discharge` is 0 and the channel has not latched, the channel freezes at the count it held just before that edge. A later crossing therefore gives a larger value.
- R7: After a channel latches, further comparator activity leaves its field unchanged until the next `field_start`.
- R8: The line count stops at 255. A channel that never crosses reads 255 once that many lines have passed.
- R9: When `field_start` arrives in the same cycle as a `line_tick` or a comparator high, `field_start` wins: the next cycle shows `discharge` 1 and `result` 0.
- R10: A change of `long_discharge` in the middle of a field has no effect until the next `field_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| line_tick | input | 1 | One-cycle pulse per scan line |
| long_discharge | input | 1 | 1 selects the 8-line discharge interval, 0 the 7-line interval |
| cmp_x | input | 1 | X comparator, 1 when the threshold is exceeded |
| cmp_y | input | 1 | Y comparator, 1 when the threshold is exceeded |
| discharge | output | 1 | Drives the capacitor discharge switches |
| result | output | 16 | Y count in bits 15:8, X count in bits 7:0 |

## Verification
Every result is due one clock edge after the input that causes it. A field start, a line tick or a comparator crossing sampled at an edge is visible on `discharge` and `result` straight after that edge; no further pipeline stage lies in the path. The bench drives inputs on the falling edge and compares the outputs on the next falling edge against a model that advances once per rising edge. Each comparison therefore falls exactly one edge after its stimulus. Directed cases check the interval boundaries, saturation and the priority of `field_start` at literal cycle positions.

// File: rtl/pot_pkg.sv
// Shared widths and types for the potentiometer scan-line converter.
package pot_pkg;
    parameter int unsigned CNT_W = 8;
    typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/pot_seq.sv
// Field sequencer: runs the discharge interval and the saturating line counter.
// Assumes field_start and line_tick are single-cycle pulses synchronous to clk.
// field_start takes priority over line_tick.
module pot_seq #(
    parameter int unsigned CNT_W       = pot_pkg::CNT_W,
    parameter int unsigned SHORT_LINES = 7,
    parameter int unsigned LONG_LINES  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic             line_tick,
    input  logic             long_discharge,
    output logic             discharge,
    output logic [CNT_W-1:0] count
);
    localparam int unsigned MAX_LINES = (LONG_LINES > SHORT_LINES) ? LONG_LINES : SHORT_LINES;
    localparam int unsigned DW        = $clog2(MAX_LINES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [DW-1:0] lines_left;

    // Count down the discharge lines; the interval length is fixed at field start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_left <= '0;
        end else if (field_start) begin
            lines_left <= long_discharge ? DW'(LONG_LINES) : DW'(SHORT_LINES);
        end else if (line_tick && (lines_left != '0)) begin
            lines_left <= lines_left - 1'b1;
        end
    end

    // Advance the line count after discharge, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (field_start) begin
            count <= '0;
        end else if (line_tick && (lines_left == '0) && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

    // The discharge switch is active while lines remain in the interval.
    always_comb discharge = (lines_left != '0);
endmodule

// File: rtl/pot_channel.sv
// One conversion channel: freezes the line count on the first comparator crossing.
// Assumes the comparator is already synchronous to clk. Crossings are ignored
// during discharge. Before latching, the output follows the running count.
module pot_channel #(
    parameter int unsigned CNT_W = pot_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic             discharge,
    input  logic             cmp,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] value,
    output logic             latched
);
    logic [CNT_W-1:0] held;

    // Capture the count on the first qualifying crossing of the field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched <= 1'b0;
            held    <= '0;
        end else if (field_start) begin
            latched <= 1'b0;
            held    <= '0;
        end else if (!latched && cmp && !discharge) begin
            latched <= 1'b1;
            held    <= count;
        end
    end

    // Show the frozen value once latched, otherwise the running count.
    always_comb value = latched ? held : count;
endmodule

// File: rtl/pot_line_counter.sv
// Top level: one sequencer shared by the X and Y channels. The result packs
// Y in the upper byte and X in the lower byte.
module pot_line_counter #(
    parameter int unsigned CNT_W       = pot_pkg::CNT_W,
    parameter int unsigned SHORT_LINES = 7,
    parameter int unsigned LONG_LINES  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               field_start,
    input  logic               line_tick,
    input  logic               long_discharge,
    input  logic               cmp_x,
    input  logic               cmp_y,
    output logic               discharge,
    output logic [2*CNT_W-1:0] result
);
    localparam int unsigned NCH = 2;

    logic [CNT_W-1:0] line_count;
    logic [NCH-1:0]   cmp_vec;
    logic [NCH-1:0]   latched;

    // Channel 0 is X (low byte), channel 1 is Y (high byte).
    always_comb cmp_vec = {cmp_y, cmp_x};

    pot_seq #(
        .CNT_W       (CNT_W),
        .SHORT_LINES (SHORT_LINES),
        .LONG_LINES  (LONG_LINES)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .field_start    (field_start),
        .line_tick      (line_tick),
        .long_discharge (long_discharge),
        .discharge      (discharge),
        .count          (line_count)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pot_channel #(.CNT_W(CNT_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .field_start (field_start),
            .discharge   (discharge),
            .cmp         (cmp_vec[ch]),
            .count       (line_count),
            .value       (result[ch*CNT_W +: CNT_W]),
            .latched     (latched[ch])
        );
    end
endmodule

// File: rtl/pot_line_counter_checker.sv
// Property checker for pot_line_counter, attached by bind below.
module pot_line_counter_checker #(
    parameter int unsigned CNT_W = pot_pkg::CNT_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               field_start,
    input logic               line_tick,
    input logic               discharge,
    input logic [2*CNT_W-1:0] result,
    input logic [1:0]         latched
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R2: a field start always opens a discharge interval.
    a_r2_start_discharges: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> discharge);

    // R2: discharge only ends on a line tick.
    a_r2_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(discharge) |-> $past(line_tick));

    // R3: both fields read zero during discharge.
    a_r3_zero_in_discharge: assert property (@(posedge clk) disable iff (!rst_n)
        discharge |-> (result == '0));

    // R4: the X field never decreases within a field.
    a_r4_x_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> (result[CNT_W-1:0] >= $past(result[CNT_W-1:0])));

    // R7: a latched X field holds until the next field start.
    a_r7_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latched[0] && !field_start) |=> $stable(result[CNT_W-1:0]));

    // R7: a latched Y field holds until the next field start.
    a_r7_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latched[1] && !field_start) |=> $stable(result[2*CNT_W-1:CNT_W]));

    // R8: a saturated Y field does not wrap.
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((result[2*CNT_W-1:CNT_W] == TOP) && !field_start) |=> (result[2*CNT_W-1:CNT_W] == TOP));
endmodule

bind pot_line_counter pot_line_counter_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .line_tick   (line_tick),
    .discharge   (discharge),
    .result      (result),
    .latched     (latched)
);

// File: tb/pot_line_counter_bench.sv
module pot_line_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_start = 1'b0;
    logic        line_tick = 1'b0;
    logic        long_discharge = 1'b0;
    logic        cmp_x = 1'b0;
    logic        cmp_y = 1'b0;
    logic        discharge;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // model state
    int m_left = 0, m_cnt = 0, m_vx = 0, m_vy = 0;
    bit m_dx = 0, m_dy = 0;

    always #2.5 clk = ~clk;

    pot_line_counter u_pot_line_counter (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_tick(line_tick),
        .long_discharge(long_discharge), .cmp_x(cmp_x), .cmp_y(cmp_y),
        .discharge(discharge), .result(result)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int exp_x();
        return m_dx ? m_vx : m_cnt;
    endfunction

    function automatic int exp_y();
        return m_dy ? m_vy : m_cnt;
    endfunction

    // Drive one cycle, advance the model at the rising edge, compare at the falling edge.
    task automatic cyc(input bit fs, input bit lt, input bit cx, input bit cy);
        field_start = fs; line_tick = lt; cmp_x = cx; cmp_y = cy;
        @(posedge clk);
        if (fs) begin
            m_left = long_discharge ? 8 : 7;
            m_cnt = 0; m_dx = 0; m_dy = 0; m_vx = 0; m_vy = 0;
        end else begin
            if (!m_dx && cx && m_left == 0) begin m_dx = 1; m_vx = m_cnt; end
            if (!m_dy && cy && m_left == 0) begin m_dy = 1; m_vy = m_cnt; end
            if (lt) begin
                if (m_left != 0) m_left--;
                else if (m_cnt != 255) m_cnt++;
            end
        end
        @(negedge clk);
        if (rst_n) begin
            chk("R5 x field", int'(result[7:0]), exp_x());
            chk("R5 y field", int'(result[15:8]), exp_y());
            chk("R2 discharge", int'(discharge), (m_left != 0) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cx_at, cy_at, nlines;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 discharge after reset", int'(discharge), 0);
        chk("R1 result after reset", int'(result), 0);

        // R2 short interval, R3 comparator ignored, R10 mode change mid-field
        long_discharge = 1'b0;
        cyc(1, 0, 0, 0);
        long_discharge = 1'b1;  // R10: must not stretch this field's interval
        for (int i = 0; i < 6; i++) cyc(0, 1, 1, 1);
        chk("R2 still discharging after 6 ticks", int'(discharge), 1);
        chk("R3 result zero despite comparator", int'(result), 0);
        cyc(0, 1, 0, 0);
        chk("R10 short interval kept after mode change", int'(discharge), 0);
        cyc(0, 1, 0, 0);
        chk("R4 first count", int'(result), 16'h0101);
        cyc(0, 1, 0, 0);
        chk("R4 second count", int'(result), 16'h0202);

        // R2 long interval
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 7; i++) cyc(0, 1, 0, 0);
        chk("R2 long interval still on after 7 ticks", int'(discharge), 1);
        cyc(0, 1, 0, 0);
        chk("R2 long interval off after 8 ticks", int'(discharge), 0);

        // R6 latch X at 5, R7 second crossing ignored
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0);
        cyc(0, 1, 1, 0);
        chk("R6 x frozen at pre-edge count", int'(result[7:0]), 5);
        chk("R5 y keeps counting", int'(result[15:8]), 6);
        cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);
        cyc(0, 1, 1, 1);
        chk("R7 x unchanged by later crossing", int'(result[7:0]), 5);
        chk("R6 y frozen later, larger value", int'(result[15:8]), 10);

        // R9 field start wins over tick and comparator
        cyc(1, 1, 1, 1);
        chk("R9 discharge after contested start", int'(discharge), 1);
        chk("R9 result cleared", int'(result), 0);

        // R8 saturation with no crossing
        long_discharge = 1'b0;
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 300; i++) cyc(0, 1, 0, 0);
        chk("R8 saturated result", int'(result), 16'hFFFF);

        // Random fields
        for (int f = 0; f < 30; f++) begin
            long_discharge = $urandom_range(0, 1);
            cyc(1, 0, 0, 0);
            nlines = $urandom_range(20, 300);
            cx_at = $urandom_range(0, nlines + 20);
            cy_at = $urandom_range(0, nlines + 20);
            for (int i = 0; i < nlines; i++) begin
                if ($urandom_range(0, 3) == 0) long_discharge = ~long_discharge;
                cyc(0, ($urandom_range(0, 2) != 0), (i >= cx_at), (i >= cy_at) && ($urandom_range(0, 4) != 0));
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule